// File: doc/BRIEF.md
# Flash Unlock Command Decoder

This block sits on the device side of a flash memory controller and watches a synchronous host write port. Each host write is one strobe cycle that carries an address and a data byte. The decoder follows the protected multi-cycle unlock sequences that guard every change to the array. When a sequence completes, it raises a single one-cycle request to the array engine: program one byte, erase one sector, erase the whole chip, enter identification mode or leave it. It also holds the identification-mode flag that the read path uses to choose between array data and identification bytes.

Command recognition uses only the low command-address bits, so the upper address bits do not matter for command cycles. The full address is kept for the byte to be programmed, and the bits from the sector boundary upward are kept as the sector number. Any write that does not fit the expected next step drops the decoder back to read mode. A write that is itself the opening unlock cycle starts a new sequence. While the array engine reports busy, every write is discarded and the sequence position is kept.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all five request outputs are 0, id_mode is 0, and prog_addr, prog_data and erase_sector are 0.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h arm a program. The next accepted write to any address pulses prog_req in the cycle after that write, with prog_addr and prog_data equal to the address and data of that write.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh followed by 30h to any address pulse sect_erase_req. erase_sector then equals address bits [ADDR_W-1:SECT_LSB] of that sixth write (bits [15:12] by default).
- R4: The same five-write prefix followed by 10h@5555h pulses chip_erase_req.
- R5: The writes AAh@5555h, 55h@2AAAh, 90h@5555h pulse id_enter_req and set id_mode to 1 in the same cycle.
- R6: From read mode, a single write of F0h to any address pulses id_exit_req and clears id_mode. The three-cycle sequence ending in F0h@5555h does the same.
- R7: A write that does not match the expected next step aborts the sequence. The later writes of the abandoned sequence then raise no request.
- R8: A mismatching write that is AAh@5555h counts as the first step of a new sequence.
- R9: A write made while busy is 1 is ignored: it raises no request, it does not change id_mode (this includes F0h), and the sequence resumes from the same step afterwards.
- R10: Command cycles compare only address bits [14:0]. Setting the bits above them (for example D555h for 5555h) makes no difference.
- R11: Each request lasts exactly one cycle, at most one request is high in any cycle, and the sequence returns to read mode in the cycle the request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| busy | input | 1 | Array engine is running a program or erase |
| prog_req | output | 1 | One-cycle byte-program request |
| sect_erase_req | output | 1 | One-cycle sector-erase request |
| chip_erase_req | output | 1 | One-cycle chip-erase request |
| id_enter_req | output | 1 | One-cycle identification-mode entry request |
| id_exit_req | output | 1 | One-cycle identification-mode exit request |
| prog_addr | output | ADDR_W | Address of the byte to program, held until the next program |
| prog_data | output | DATA_W | Data of the byte to program, held until the next program |
| erase_sector | output | ADDR_W-SECT_LSB | Sector to erase, held until the next sector erase |
| id_mode | output | 1 | Identification-mode flag for the read path |

## Verification
The assertions check on every cycle the following:
- a busy write leaves the step and the flag untouched and raises nothing;
- no request appears without a write in the cycle before;
- every request finds the sequence already back in read mode;
- no program or erase request is raised twice in a row;
- the payload registers change only when a new request loads them;
- the flag agrees with the entry and exit pulses.

Only the bench scenarios can show the rest: that the right byte codes at the right addresses, in order, lead to the right request; that aborts and restarts fall on the right step; that upper address bits are ignored; and that the captured address, data and sector are correct. The bench shows these with directed sequences and a long seeded random mix of valid and stray writes, compared against a step model kept in the bench.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  // sequence position: which step of an unlock chain has been matched
  typedef enum logic [2:0] {
    ST_READ,   // no sequence in progress
    ST_U1,     // first unlock cycle seen
    ST_U2,     // second unlock cycle seen, waiting for the command byte
    ST_PROG,   // program armed, next write is the target byte
    ST_E3,     // erase prefix seen, waiting for the second first-unlock
    ST_E4,     // second first-unlock seen
    ST_E5      // second second-unlock seen, waiting for the erase kind
  } step_t;

  // requested operation
  typedef enum logic [2:0] {
    OP_NONE,
    OP_PROG,
    OP_SECT,
    OP_CHIP,
    OP_ID_IN,
    OP_ID_OUT
  } op_t;

  // classification of one write
  typedef struct packed {
    logic unl1;      // AAh to the first unlock address
    logic unl2;      // 55h to the second unlock address
    logic arm_prog;  // A0h to the first unlock address
    logic arm_erase; // 80h to the first unlock address
    logic id_in;     // 90h to the first unlock address
    logic id_out3;   // F0h to the first unlock address
    logic reset_any; // F0h to any address
    logic sect;      // 30h to any address
    logic chip;      // 10h to the first unlock address
  } hit_t;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;

  localparam logic [7:0] CODE_UNL1  = 8'hAA;
  localparam logic [7:0] CODE_UNL2  = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_ID_IN = 8'h90;
  localparam logic [7:0] CODE_RESET = 8'hF0;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_CHIP  = 8'h10;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CMD_W  = 15
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output hit_t              hit
);

  localparam logic [CMD_W-1:0] ADR_A = UNLOCK_ADDR_A[CMD_W-1:0];
  localparam logic [CMD_W-1:0] ADR_B = UNLOCK_ADDR_B[CMD_W-1:0];

  logic [CMD_W-1:0] cmd_addr;
  logic             at_a;
  logic             at_b;

  // only the low command bits take part in the comparison
  assign cmd_addr = wr_addr[CMD_W-1:0];
  assign at_a     = (cmd_addr == ADR_A);
  assign at_b     = (cmd_addr == ADR_B);

  always_comb begin
    hit           = '0;
    hit.unl1      = at_a && (wr_data == DATA_W'(CODE_UNL1));
    hit.unl2      = at_b && (wr_data == DATA_W'(CODE_UNL2));
    hit.arm_prog  = at_a && (wr_data == DATA_W'(CODE_PROG));
    hit.arm_erase = at_a && (wr_data == DATA_W'(CODE_ERASE));
    hit.id_in     = at_a && (wr_data == DATA_W'(CODE_ID_IN));
    hit.id_out3   = at_a && (wr_data == DATA_W'(CODE_RESET));
    hit.reset_any = (wr_data == DATA_W'(CODE_RESET));
    hit.sect      = (wr_data == DATA_W'(CODE_SECT));
    hit.chip      = at_a && (wr_data == DATA_W'(CODE_CHIP));
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_stb,
  input  logic  busy,
  input  hit_t  hit,
  output step_t step,
  output op_t   op_next,
  output op_t   op_q
);

  step_t step_n;
  logic  take;

  assign take = wr_stb && !busy;

  always_comb begin
    step_n  = step;
    op_next = OP_NONE;
    if (take) begin
      step_n = ST_READ;
      unique case (step)
        ST_READ: begin
          if (hit.unl1)           step_n  = ST_U1;
          else if (hit.reset_any) op_next = OP_ID_OUT;
        end
        ST_U1: begin
          if (hit.unl2)      step_n = ST_U2;
          else if (hit.unl1) step_n = ST_U1;
        end
        ST_U2: begin
          if (hit.arm_prog)       step_n  = ST_PROG;
          else if (hit.arm_erase) step_n  = ST_E3;
          else if (hit.id_in)     op_next = OP_ID_IN;
          else if (hit.id_out3)   op_next = OP_ID_OUT;
          else if (hit.unl1)      step_n  = ST_U1;
        end
        ST_PROG: op_next = OP_PROG;
        ST_E3: begin
          if (hit.unl1) step_n = ST_E4;
        end
        ST_E4: begin
          if (hit.unl2)      step_n = ST_E5;
          else if (hit.unl1) step_n = ST_U1;
        end
        ST_E5: begin
          if (hit.sect)      op_next = OP_SECT;
          else if (hit.chip) op_next = OP_CHIP;
          else if (hit.unl1) step_n  = ST_U1;
        end
        default: step_n = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= ST_READ;
      op_q <= OP_NONE;
    end else begin
      step <= step_n;
      op_q <= op_next;
    end
  end

  // R9: a write during busy changes nothing and requests nothing
  p_busy_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && busy) |=> ($stable(step) && op_q == OP_NONE));

  // R11: a request is only ever the answer to a write
  p_op_needs_write_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> (op_q == OP_NONE));

  // R11: the sequence has cleared when the request shows
  p_clear_with_op_r11: assert property (@(posedge clk) disable iff (rst)
    (op_q != OP_NONE) |-> (step == ST_READ));

  // R2: a program request follows a write in the armed step
  p_prog_from_armed_r2: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_PROG) |-> ($past(step) == ST_PROG));

  // R3, R4: erase requests follow the sixth-cycle step
  p_erase_from_e5_r3: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_SECT || op_q == OP_CHIP) |-> ($past(step) == ST_E5));

endmodule

// File: rtl/flash_cmd_payload.sv
module flash_cmd_payload
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SECT_LSB = 12,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  op_t               op_next,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [SECT_W-1:0] erase_sector
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_addr    <= '0;
      prog_data    <= '0;
      erase_sector <= '0;
    end else begin
      if (op_next == OP_PROG) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (op_next == OP_SECT) begin
        erase_sector <= wr_addr[ADDR_W-1:SECT_LSB];
      end
    end
  end

  // R2: program payload holds between program requests
  p_prog_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (op_next != OP_PROG) |=> ($stable(prog_addr) && $stable(prog_data)));

  // R3: sector number holds between sector-erase requests
  p_sect_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (op_next != OP_SECT) |=> $stable(erase_sector));

endmodule

// File: rtl/flash_id_flag.sv
module flash_id_flag
  import flash_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_t  op_next,
  output logic id_mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      id_mode <= 1'b0;
    end else if (op_next == OP_ID_IN) begin
      id_mode <= 1'b1;
    end else if (op_next == OP_ID_OUT) begin
      id_mode <= 1'b0;
    end
  end

  // R6, R9: the flag changes only in answer to an entry or exit
  p_flag_moves_on_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    (op_next != OP_ID_IN && op_next != OP_ID_OUT) |=> $stable(id_mode));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CMD_W    = 15,
  parameter int SECT_LSB = 12,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              prog_req,
  output logic              sect_erase_req,
  output logic              chip_erase_req,
  output logic              id_enter_req,
  output logic              id_exit_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [SECT_W-1:0] erase_sector,
  output logic              id_mode
);

  hit_t  hit;
  step_t step;
  op_t   op_next;
  op_t   op_q;

  flash_cmd_match #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CMD_W  (CMD_W)
  ) u_match (
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hit     (hit)
  );

  flash_cmd_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .busy    (busy),
    .hit     (hit),
    .step    (step),
    .op_next (op_next),
    .op_q    (op_q)
  );

  flash_cmd_payload #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SECT_LSB (SECT_LSB)
  ) u_payload (
    .clk          (clk),
    .rst          (rst),
    .op_next      (op_next),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .prog_addr    (prog_addr),
    .prog_data    (prog_data),
    .erase_sector (erase_sector)
  );

  flash_id_flag u_id (
    .clk     (clk),
    .rst     (rst),
    .op_next (op_next),
    .id_mode (id_mode)
  );

  // request pulses decode the registered operation
  assign prog_req       = (op_q == OP_PROG);
  assign sect_erase_req = (op_q == OP_SECT);
  assign chip_erase_req = (op_q == OP_CHIP);
  assign id_enter_req   = (op_q == OP_ID_IN);
  assign id_exit_req    = (op_q == OP_ID_OUT);

  // R5: the flag is set by the time the entry pulse shows
  p_enter_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    id_enter_req |-> id_mode);

  // R6: the flag is clear by the time the exit pulse shows
  p_exit_clears_flag_r6: assert property (@(posedge clk) disable iff (rst)
    id_exit_req |-> !id_mode);

  // R11: array requests never repeat in consecutive cycles
  p_prog_single_r11: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req);

  p_erase_single_r11: assert property (@(posedge clk) disable iff (rst)
    (sect_erase_req || chip_erase_req) |=> !(sect_erase_req || chip_erase_req));

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int SL = 12;
  localparam int SW = AW - SL;

  localparam logic [4:0] Q_NONE = 5'b00000;
  localparam logic [4:0] Q_PROG = 5'b10000;
  localparam logic [4:0] Q_SECT = 5'b01000;
  localparam logic [4:0] Q_CHIP = 5'b00100;
  localparam logic [4:0] Q_IDIN = 5'b00010;
  localparam logic [4:0] Q_IDEX = 5'b00001;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          prog_req, sect_erase_req, chip_erase_req, id_enter_req, id_exit_req;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic [SW-1:0] erase_sector;
  logic          id_mode;

  flash_cmd_decoder uut (
    .clk (clk), .rst (rst), .wr_stb (wr_stb), .wr_addr (wr_addr),
    .wr_data (wr_data), .busy (busy), .prog_req (prog_req),
    .sect_erase_req (sect_erase_req), .chip_erase_req (chip_erase_req),
    .id_enter_req (id_enter_req), .id_exit_req (id_exit_req),
    .prog_addr (prog_addr), .prog_data (prog_data),
    .erase_sector (erase_sector), .id_mode (id_mode)
  );

  always #5 clk = ~clk;

  wire [4:0] pv = {prog_req, sect_erase_req, chip_erase_req, id_enter_req, id_exit_req};

  int n_chk = 0;
  int n_bad = 0;

  // bench step model: 0 read, 1 u1, 2 u2, 3 armed, 4 e3, 5 e4, 6 e5
  int            m_step = 0;
  bit            m_id = 1'b0;
  logic [AW-1:0] m_paddr = '0;
  logic [DW-1:0] m_pdata = '0;
  logic [SW-1:0] m_sect = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit b);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_addr = a;
    wr_data = d;
    busy    = b;
    @(negedge clk);
    wr_stb  = 1'b0;
    busy    = 1'b0;
  endtask

  // check the pulse right after a write, then its end one cycle later
  task automatic expect_req(input string tag, input logic [4:0] e);
    chk(tag, 32'(pv), 32'(e));
    @(negedge clk);
    chk({tag, " one-cycle R11"}, 32'(pv), 32'(Q_NONE));
  endtask

  task automatic unlock(input logic [AW-1:0] hi);
    wr(hi | 16'h5555, 8'hAA, 1'b0);
    wr(hi | 16'h2AAA, 8'h55, 1'b0);
  endtask

  // expected result of one write, from the requirements
  task automatic model(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit b,
                       output logic [4:0] q);
    logic [14:0] ca;
    bit at_a, at_b, u1, u2;
    int ns;
    ca   = a[14:0];
    at_a = (ca == 15'h5555);
    at_b = (ca == 15'h2AAA);
    u1   = at_a && d == 8'hAA;
    u2   = at_b && d == 8'h55;
    q    = Q_NONE;
    if (b) return;
    ns = 0;
    case (m_step)
      0: if (u1) ns = 1; else if (d == 8'hF0) q = Q_IDEX;
      1: if (u2) ns = 2; else if (u1) ns = 1;
      2: if (at_a && d == 8'hA0) ns = 3;
         else if (at_a && d == 8'h80) ns = 4;
         else if (at_a && d == 8'h90) q = Q_IDIN;
         else if (at_a && d == 8'hF0) q = Q_IDEX;
         else if (u1) ns = 1;
      3: q = Q_PROG;
      4: if (u1) ns = 5;
      5: if (u2) ns = 6; else if (u1) ns = 1;
      6: if (d == 8'h30) q = Q_SECT;
         else if (at_a && d == 8'h10) q = Q_CHIP;
         else if (u1) ns = 1;
      default: ns = 0;
    endcase
    m_step = ns;
    if (q == Q_IDIN) m_id = 1'b1;
    if (q == Q_IDEX) m_id = 1'b0;
    if (q == Q_PROG) begin m_paddr = a; m_pdata = d; end
    if (q == Q_SECT) m_sect = a[AW-1:SL];
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [4:0]    q;
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
    bit            rb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 requests", 32'(pv), 32'(Q_NONE));
    chk("R1 id_mode", 32'(id_mode), 0);
    chk("R1 prog_addr", 32'(prog_addr), 0);
    chk("R1 prog_data", 32'(prog_data), 0);
    chk("R1 erase_sector", 32'(erase_sector), 0);

    // R2 byte program
    unlock(16'h0000);
    wr(16'h5555, 8'hA0, 1'b0);
    chk("R2 no early req", 32'(pv), 32'(Q_NONE));
    wr(16'h8123, 8'h5A, 1'b0);
    chk("R2 prog_addr", 32'(prog_addr), 32'h8123);
    chk("R2 prog_data", 32'(prog_data), 32'h5A);
    expect_req("R2 prog_req", Q_PROG);

    // R3 sector erase
    unlock(16'h0000);
    wr(16'h5555, 8'h80, 1'b0);
    unlock(16'h0000);
    wr(16'hB777, 8'h30, 1'b0);
    chk("R3 erase_sector", 32'(erase_sector), 32'hB);
    expect_req("R3 sect_erase_req", Q_SECT);

    // R4 chip erase, with R10 upper address bits set on every cycle
    unlock(16'h8000);
    wr(16'hD555, 8'h80, 1'b0);
    unlock(16'h8000);
    wr(16'hD555, 8'h10, 1'b0);
    expect_req("R4 R10 chip_erase_req", Q_CHIP);

    // R5 entry, R6 single-write exit
    unlock(16'h0000);
    wr(16'h5555, 8'h90, 1'b0);
    chk("R5 id_mode set", 32'(id_mode), 1);
    expect_req("R5 id_enter_req", Q_IDIN);
    wr(16'h1234, 8'hF0, 1'b0);
    chk("R6 single exit clears id_mode", 32'(id_mode), 0);
    expect_req("R6 id_exit_req single", Q_IDEX);

    // R6 three-cycle exit; R9 busy F0 does not exit
    unlock(16'h0000);
    wr(16'h5555, 8'h90, 1'b0);
    @(negedge clk);
    wr(16'h0042, 8'hF0, 1'b1);
    chk("R9 busy F0 ignored", 32'({pv, id_mode}), 32'({Q_NONE, 1'b1}));
    unlock(16'h0000);
    wr(16'h5555, 8'hF0, 1'b0);
    chk("R6 three-cycle exit id_mode", 32'(id_mode), 0);
    expect_req("R6 id_exit_req three-cycle", Q_IDEX);

    // R7 abort: wrong third byte, then the rest raises nothing
    unlock(16'h0000);
    wr(16'h5555, 8'h77, 1'b0);
    wr(16'h5555, 8'hA0, 1'b0);
    wr(16'h0100, 8'h12, 1'b0);
    chk("R7 aborted program", 32'({pv, prog_addr}), 32'({Q_NONE, 16'h8123}));

    // R8 restart at a mismatching unlock cycle
    unlock(16'h0000);
    wr(16'h5555, 8'hAA, 1'b0);
    wr(16'h2AAA, 8'h55, 1'b0);
    wr(16'h5555, 8'hA0, 1'b0);
    wr(16'h0ABC, 8'hC3, 1'b0);
    chk("R8 restart prog_addr", 32'(prog_addr), 32'h0ABC);
    expect_req("R8 restart prog_req", Q_PROG);

    // R9 busy writes keep the step
    wr(16'h5555, 8'hAA, 1'b0);
    wr(16'h7777, 8'hF0, 1'b1);
    wr(16'h1111, 8'h00, 1'b1);
    wr(16'h2AAA, 8'h55, 1'b0);
    wr(16'h5555, 8'hA0, 1'b0);
    wr(16'h0201, 8'h99, 1'b1);
    chk("R9 busy target byte ignored", 32'(pv), 32'(Q_NONE));
    wr(16'h0202, 8'h66, 1'b0);
    chk("R9 resumed prog_data", 32'(prog_data), 32'h66);
    expect_req("R9 resumed prog_req", Q_PROG);

    // seeded random mix checked against the bench model
    m_step = 0;
    m_id = id_mode;
    m_paddr = prog_addr;
    m_pdata = prog_data;
    m_sect = erase_sector;
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      ra = {1'($urandom_range(0, 1)), 15'h5555};
      case ($urandom_range(0, 10))
        0, 1: rd = 8'hAA;
        2, 3: begin ra = {1'($urandom_range(0, 1)), 15'h2AAA}; rd = 8'h55; end
        4:    rd = 8'hA0;
        5:    rd = 8'h80;
        6:    rd = 8'h90;
        7:    begin rd = 8'hF0; if ($urandom_range(0, 1) == 1) ra = 16'($urandom); end
        8:    rd = 8'h10;
        9:    begin ra = 16'($urandom); rd = 8'h30; end
        default: begin ra = 16'($urandom); rd = 8'($urandom); end
      endcase
      rb = ($urandom_range(0, 7) == 0);
      model(ra, rd, rb, q);
      wr(ra, rd, rb);
      chk("R11 random requests", 32'(pv), 32'(q));
      chk("R6 random id_mode", 32'(id_mode), 32'(m_id));
      chk("R2 random prog payload", 32'({prog_addr, prog_data}), 32'({m_paddr, m_pdata}));
      chk("R3 random sector", 32'(erase_sector), 32'(m_sect));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule